// File: doc/BRIEF.md
# Video Mode Geometry Validator

This block turns the raw mode settings of a linear framebuffer display into a checked geometry. It takes the enable word, the colour depth, the visible width and height, the virtual line width, the horizontal and vertical pan offsets, the size of the video memory in bytes and a byte-order flag. It produces a valid flag, the number of bytes per pixel, a pixel format code, the width and height, the line stride in bytes, the byte offset of the first visible pixel and the byte size of the visible region.

The block has two register stages. The first stage decodes the depth and widens the virtual width. The second stage does the arithmetic, applies the checks and registers the outputs. The last valid geometry is held in a latch. A one-cycle `mode_changed` pulse tells the scan-out logic to rebuild its surface whenever a newly validated geometry differs from the latched one. While the settings are invalid, the latch keeps its contents.

Top module: `mode_geom_top`

## Requirements
- R1: Only settings with bit 0 of `cfg_enable` set can produce a valid geometry. With that bit clear, `geo_valid` is 0.
- R2: A depth of 16 gives 2 bytes per pixel and format code 1. A depth of 32 gives 4 bytes per pixel and format code 2 (little-endian) or 3 (big-endian). Any other depth is invalid.
- R3: With a depth of 16, `big_endian` has no effect on any output, including `mode_changed`.
- R4: A virtual width below the visible width is replaced by the visible width when the stride is computed.
- R5: `stride` equals the effective virtual width times the bytes per pixel. `fb_size` equals `stride` times the height.
- R6: `start_ofs` equals the X pan times the bytes per pixel plus the Y pan times the stride. It is carried at full width with no wrap, so a huge pan is rejected rather than folded back.
- R7: A width or height below 64 is invalid. Exactly 64 is accepted.
- R8: The mode is invalid when `start_ofs + fb_size` is greater than `mem_bytes`. Exact equality is accepted.
- R9: While invalid, and after reset, every geometry output is 0 and the format code is 0 (none).
- R10: `mode_changed` is high for one cycle when a valid geometry differs from the latched one, or when no geometry has been latched yet. It stays low for a repeated geometry, during invalid cycles, and on a return to the latched geometry after an invalid stretch.
- R11: Every output reflects the inputs sampled two rising edges earlier, and a new input set is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 16 | Enable word; bit 0 turns the mode on |
| cfg_depth | input | 16 | Colour depth in bits per pixel |
| cfg_hres | input | DIM_W | Visible width in pixels |
| cfg_vres | input | DIM_W | Visible height in lines |
| cfg_vwidth | input | DIM_W | Virtual line width in pixels |
| cfg_xpan | input | DIM_W | Horizontal pan in pixels |
| cfg_ypan | input | DIM_W | Vertical pan in lines |
| mem_bytes | input | MEM_W | Video memory size in bytes |
| big_endian | input | 1 | Byte order for 32-bit pixels |
| geo_valid | output | 1 | Geometry is valid |
| bytes_pp | output | 3 | Bytes per pixel |
| pix_fmt | output | 2 | Format code: 0 none, 1 5-6-5, 2 x8r8g8b8 LE, 3 x8r8g8b8 BE |
| width | output | DIM_W | Visible width |
| height | output | DIM_W | Visible height |
| stride | output | DIM_W+3 | Line stride in bytes |
| start_ofs | output | 2*DIM_W+4 | Byte offset of the first visible pixel |
| fb_size | output | 2*DIM_W+3 | Byte size of the visible region |
| mode_changed | output | 1 | One-cycle pulse on a new valid geometry |

## Verification
Change detection and rejection interact in the same cycle when an invalid set sits between two valid ones. The pulse must then compare against the latched geometry, not the output of the previous cycle. The bench provokes this with back-to-back sets: a valid mode, an invalid depth, then the same mode again. It also uses a valid mode, then a too-narrow width, then a different mode. For each cycle it checks the pulse against a model latch, which it updates only on valid cycles. Byte-order toggles run in both depths in consecutive cycles, so a format change and a suppressed change arrive one right after the other.

// File: rtl/vmg_pkg.sv
package vmg_pkg;

    typedef enum logic [1:0] {
        FMT_NONE    = 2'd0,
        FMT_RGB565  = 2'd1,
        FMT_XRGB_LE = 2'd2,
        FMT_XRGB_BE = 2'd3
    } pix_fmt_e;

    function automatic logic [2:0] depth_bytes(input logic [15:0] depth);
        case (depth)
            16'd16:  return 3'd2;
            16'd32:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic pix_fmt_e pick_fmt(input logic [2:0] bpp, input logic be);
        case (bpp)
            3'd2:    return FMT_RGB565;
            3'd4:    return be ? FMT_XRGB_BE : FMT_XRGB_LE;
            default: return FMT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/vmg_decode.sv
module vmg_decode
    import vmg_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int MEM_W  = 32,
    parameter int EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      en_word,
    input  logic [15:0]      depth,
    input  logic [DIM_W-1:0] hres,
    input  logic [DIM_W-1:0] vres,
    input  logic [DIM_W-1:0] vwid,
    input  logic [DIM_W-1:0] xpan,
    input  logic [DIM_W-1:0] ypan,
    input  logic [MEM_W-1:0] mem_in,
    input  logic             be_in,
    output logic             s1_ok,
    output logic [2:0]       s1_bpp,
    output logic [1:0]       s1_fmt,
    output logic [DIM_W-1:0] s1_w,
    output logic [DIM_W-1:0] s1_h,
    output logic [DIM_W-1:0] s1_vw,
    output logic [DIM_W-1:0] s1_x,
    output logic [DIM_W-1:0] s1_y,
    output logic [MEM_W-1:0] s1_mem
);

    logic [2:0]       bpp_d;
    pix_fmt_e         fmt_d;
    logic [DIM_W-1:0] vw_d;

    always_comb begin
        bpp_d = depth_bytes(depth);
        fmt_d = pick_fmt(bpp_d, be_in);
        vw_d  = (vwid < hres) ? hres : vwid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ok  <= 1'b0;
            s1_bpp <= '0;
            s1_fmt <= FMT_NONE;
            s1_w   <= '0;
            s1_h   <= '0;
            s1_vw  <= '0;
            s1_x   <= '0;
            s1_y   <= '0;
            s1_mem <= '0;
        end else begin
            s1_ok  <= en_word[EN_BIT] && (bpp_d != 3'd0);
            s1_bpp <= bpp_d;
            s1_fmt <= fmt_d;
            s1_w   <= hres;
            s1_h   <= vres;
            s1_vw  <= vw_d;
            s1_x   <= xpan;
            s1_y   <= ypan;
            s1_mem <= mem_in;
        end
    end

endmodule

// File: rtl/vmg_calc.sv
module vmg_calc #(
    parameter int DIM_W   = 16,
    parameter int MEM_W   = 32,
    parameter int MIN_DIM = 64,
    localparam int STRIDE_W = DIM_W + 3,
    localparam int SIZE_W   = STRIDE_W + DIM_W,
    localparam int OFS_W    = SIZE_W + 1,
    localparam int END_W    = OFS_W + 1
) (
    input  logic                s1_ok,
    input  logic [2:0]          s1_bpp,
    input  logic [1:0]          s1_fmt,
    input  logic [DIM_W-1:0]    s1_w,
    input  logic [DIM_W-1:0]    s1_h,
    input  logic [DIM_W-1:0]    s1_vw,
    input  logic [DIM_W-1:0]    s1_x,
    input  logic [DIM_W-1:0]    s1_y,
    input  logic [MEM_W-1:0]    s1_mem,
    output logic                c_valid,
    output logic [2:0]          c_bpp,
    output logic [1:0]          c_fmt,
    output logic [DIM_W-1:0]    c_w,
    output logic [DIM_W-1:0]    c_h,
    output logic [STRIDE_W-1:0] c_stride,
    output logic [OFS_W-1:0]    c_ofs,
    output logic [SIZE_W-1:0]   c_size
);

    localparam logic [DIM_W-1:0] MIN_V = DIM_W'(MIN_DIM);

    logic [STRIDE_W-1:0] str_w;
    logic [STRIDE_W-1:0] xb_w;
    logic [SIZE_W-1:0]   size_w;
    logic [SIZE_W-1:0]   yb_w;
    logic [OFS_W-1:0]    ofs_w;
    logic [END_W-1:0]    end_w;
    logic                dim_ok;
    logic                fit_ok;

    always_comb begin
        str_w  = STRIDE_W'(s1_vw) * STRIDE_W'(s1_bpp);
        xb_w   = STRIDE_W'(s1_x) * STRIDE_W'(s1_bpp);
        size_w = SIZE_W'(str_w) * SIZE_W'(s1_h);
        yb_w   = SIZE_W'(str_w) * SIZE_W'(s1_y);
        ofs_w  = OFS_W'(yb_w) + OFS_W'(xb_w);
        end_w  = END_W'(ofs_w) + END_W'(size_w);
        dim_ok = (s1_w >= MIN_V) && (s1_h >= MIN_V);
        fit_ok = end_w <= END_W'(s1_mem);
        c_valid  = s1_ok && dim_ok && fit_ok;
        c_bpp    = c_valid ? s1_bpp : '0;
        c_fmt    = c_valid ? s1_fmt : '0;
        c_w      = c_valid ? s1_w   : '0;
        c_h      = c_valid ? s1_h   : '0;
        c_stride = c_valid ? str_w  : '0;
        c_ofs    = c_valid ? ofs_w  : '0;
        c_size   = c_valid ? size_w : '0;
    end

endmodule

// File: rtl/vmg_track.sv
module vmg_track #(
    parameter int DIM_W = 16,
    localparam int STRIDE_W = DIM_W + 3,
    localparam int SIZE_W   = STRIDE_W + DIM_W,
    localparam int OFS_W    = SIZE_W + 1,
    localparam int GEO_W    = 3 + 2 + 2 * DIM_W + STRIDE_W + OFS_W + SIZE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                c_valid,
    input  logic [2:0]          c_bpp,
    input  logic [1:0]          c_fmt,
    input  logic [DIM_W-1:0]    c_w,
    input  logic [DIM_W-1:0]    c_h,
    input  logic [STRIDE_W-1:0] c_stride,
    input  logic [OFS_W-1:0]    c_ofs,
    input  logic [SIZE_W-1:0]   c_size,
    output logic                o_valid,
    output logic [2:0]          o_bpp,
    output logic [1:0]          o_fmt,
    output logic [DIM_W-1:0]    o_w,
    output logic [DIM_W-1:0]    o_h,
    output logic [STRIDE_W-1:0] o_stride,
    output logic [OFS_W-1:0]    o_ofs,
    output logic [SIZE_W-1:0]   o_size,
    output logic                o_changed
);

    logic             held_any;
    logic [GEO_W-1:0] held_geo;
    logic [GEO_W-1:0] cand_geo;
    logic             differs;

    always_comb begin
        cand_geo = {c_bpp, c_fmt, c_w, c_h, c_stride, c_ofs, c_size};
        differs  = !held_any || (cand_geo != held_geo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid   <= 1'b0;
            o_bpp     <= '0;
            o_fmt     <= '0;
            o_w       <= '0;
            o_h       <= '0;
            o_stride  <= '0;
            o_ofs     <= '0;
            o_size    <= '0;
            o_changed <= 1'b0;
            held_any  <= 1'b0;
            held_geo  <= '0;
        end else begin
            o_valid   <= c_valid;
            o_bpp     <= c_bpp;
            o_fmt     <= c_fmt;
            o_w       <= c_w;
            o_h       <= c_h;
            o_stride  <= c_stride;
            o_ofs     <= c_ofs;
            o_size    <= c_size;
            o_changed <= c_valid && differs;
            if (c_valid && differs) begin
                held_any <= 1'b1;
                held_geo <= cand_geo;
            end
        end
    end

endmodule

// File: rtl/mode_geom_top.sv
module mode_geom_top #(
    parameter int DIM_W   = 16,
    parameter int MEM_W   = 32,
    parameter int MIN_DIM = 64,
    localparam int STRIDE_W = DIM_W + 3,
    localparam int SIZE_W   = STRIDE_W + DIM_W,
    localparam int OFS_W    = SIZE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         cfg_enable,
    input  logic [15:0]         cfg_depth,
    input  logic [DIM_W-1:0]    cfg_hres,
    input  logic [DIM_W-1:0]    cfg_vres,
    input  logic [DIM_W-1:0]    cfg_vwidth,
    input  logic [DIM_W-1:0]    cfg_xpan,
    input  logic [DIM_W-1:0]    cfg_ypan,
    input  logic [MEM_W-1:0]    mem_bytes,
    input  logic                big_endian,
    output logic                geo_valid,
    output logic [2:0]          bytes_pp,
    output logic [1:0]          pix_fmt,
    output logic [DIM_W-1:0]    width,
    output logic [DIM_W-1:0]    height,
    output logic [STRIDE_W-1:0] stride,
    output logic [OFS_W-1:0]    start_ofs,
    output logic [SIZE_W-1:0]   fb_size,
    output logic                mode_changed
);

    logic                s1_ok;
    logic [2:0]          s1_bpp;
    logic [1:0]          s1_fmt;
    logic [DIM_W-1:0]    s1_w, s1_h, s1_vw, s1_x, s1_y;
    logic [MEM_W-1:0]    s1_mem;

    logic                c_valid;
    logic [2:0]          c_bpp;
    logic [1:0]          c_fmt;
    logic [DIM_W-1:0]    c_w, c_h;
    logic [STRIDE_W-1:0] c_stride;
    logic [OFS_W-1:0]    c_ofs;
    logic [SIZE_W-1:0]   c_size;

    vmg_decode #(.DIM_W(DIM_W), .MEM_W(MEM_W), .EN_BIT(0)) u_dec (
        .clk(clk), .rst(rst),
        .en_word(cfg_enable), .depth(cfg_depth),
        .hres(cfg_hres), .vres(cfg_vres), .vwid(cfg_vwidth),
        .xpan(cfg_xpan), .ypan(cfg_ypan),
        .mem_in(mem_bytes), .be_in(big_endian),
        .s1_ok(s1_ok), .s1_bpp(s1_bpp), .s1_fmt(s1_fmt),
        .s1_w(s1_w), .s1_h(s1_h), .s1_vw(s1_vw),
        .s1_x(s1_x), .s1_y(s1_y), .s1_mem(s1_mem)
    );

    vmg_calc #(.DIM_W(DIM_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM)) u_calc (
        .s1_ok(s1_ok), .s1_bpp(s1_bpp), .s1_fmt(s1_fmt),
        .s1_w(s1_w), .s1_h(s1_h), .s1_vw(s1_vw),
        .s1_x(s1_x), .s1_y(s1_y), .s1_mem(s1_mem),
        .c_valid(c_valid), .c_bpp(c_bpp), .c_fmt(c_fmt),
        .c_w(c_w), .c_h(c_h), .c_stride(c_stride),
        .c_ofs(c_ofs), .c_size(c_size)
    );

    vmg_track #(.DIM_W(DIM_W)) u_track (
        .clk(clk), .rst(rst),
        .c_valid(c_valid), .c_bpp(c_bpp), .c_fmt(c_fmt),
        .c_w(c_w), .c_h(c_h), .c_stride(c_stride),
        .c_ofs(c_ofs), .c_size(c_size),
        .o_valid(geo_valid), .o_bpp(bytes_pp), .o_fmt(pix_fmt),
        .o_w(width), .o_h(height), .o_stride(stride),
        .o_ofs(start_ofs), .o_size(fb_size), .o_changed(mode_changed)
    );

endmodule

// File: rtl/vmg_checker.sv
module vmg_checker #(
    parameter int DIM_W   = 16,
    parameter int MEM_W   = 32,
    parameter int MIN_DIM = 64,
    localparam int STRIDE_W = DIM_W + 3,
    localparam int SIZE_W   = STRIDE_W + DIM_W,
    localparam int OFS_W    = SIZE_W + 1,
    localparam int END_W    = OFS_W + 1
) (
    input logic                clk,
    input logic                rst,
    input logic [MEM_W-1:0]    mem_bytes,
    input logic                geo_valid,
    input logic [2:0]          bytes_pp,
    input logic [1:0]          pix_fmt,
    input logic [DIM_W-1:0]    width,
    input logic [DIM_W-1:0]    height,
    input logic [STRIDE_W-1:0] stride,
    input logic [OFS_W-1:0]    start_ofs,
    input logic [SIZE_W-1:0]   fb_size,
    input logic                mode_changed
);

    localparam logic [DIM_W-1:0] MIN_V = DIM_W'(MIN_DIM);

    // R2: bytes per pixel and format code agree
    p_fmt_bytes_r2: assert property (@(posedge clk) disable iff (rst)
        geo_valid |-> ((bytes_pp == 3'd2 && pix_fmt == 2'd1) ||
                       (bytes_pp == 3'd4 && pix_fmt[1])));

    // R4: stride never narrower than the visible line
    p_stride_cover_r4: assert property (@(posedge clk) disable iff (rst)
        geo_valid |-> (stride >= STRIDE_W'(width) * STRIDE_W'(bytes_pp)));

    // R7: dimension floor
    p_min_dim_r7: assert property (@(posedge clk) disable iff (rst)
        geo_valid |-> (width >= MIN_V && height >= MIN_V));

    // R8: visible region fits in memory sampled two edges earlier
    p_fits_mem_r8: assert property (@(posedge clk) disable iff (rst)
        geo_valid |-> (END_W'(start_ofs) + END_W'(fb_size) <= END_W'($past(mem_bytes, 2))));

    // R9: blank outputs while invalid
    p_blank_r9: assert property (@(posedge clk) disable iff (rst)
        !geo_valid |-> (bytes_pp == 0 && pix_fmt == 0 && width == 0 && height == 0 &&
                        stride == 0 && start_ofs == 0 && fb_size == 0));

    // R10: pulse only with a valid geometry
    p_pulse_valid_r10: assert property (@(posedge clk) disable iff (rst)
        mode_changed |-> geo_valid);

    // R10: an unchanged valid geometry stays quiet
    p_repeat_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (geo_valid && $past(geo_valid) && $stable(pix_fmt) && $stable(width) &&
         $stable(height) && $stable(stride) && $stable(start_ofs) &&
         $stable(fb_size) && $stable(bytes_pp)) |-> !mode_changed);

endmodule

bind mode_geom_top vmg_checker #(.DIM_W(DIM_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM)) u_chk (
    .clk(clk), .rst(rst), .mem_bytes(mem_bytes),
    .geo_valid(geo_valid), .bytes_pp(bytes_pp), .pix_fmt(pix_fmt),
    .width(width), .height(height), .stride(stride),
    .start_ofs(start_ofs), .fb_size(fb_size), .mode_changed(mode_changed)
);

// File: tb/tb_mode_geom_top.sv
module tb_mode_geom_top;

    localparam int DIM_W    = 16;
    localparam int MEM_W    = 32;
    localparam int STRIDE_W = DIM_W + 3;
    localparam int SIZE_W   = STRIDE_W + DIM_W;
    localparam int OFS_W    = SIZE_W + 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [15:0]         cfg_enable = '0;
    logic [15:0]         cfg_depth = '0;
    logic [DIM_W-1:0]    cfg_hres = '0, cfg_vres = '0, cfg_vwidth = '0;
    logic [DIM_W-1:0]    cfg_xpan = '0, cfg_ypan = '0;
    logic [MEM_W-1:0]    mem_bytes = '0;
    logic                big_endian = 1'b0;
    logic                geo_valid;
    logic [2:0]          bytes_pp;
    logic [1:0]          pix_fmt;
    logic [DIM_W-1:0]    width, height;
    logic [STRIDE_W-1:0] stride;
    logic [OFS_W-1:0]    start_ofs;
    logic [SIZE_W-1:0]   fb_size;
    logic                mode_changed;

    mode_geom_top #(.DIM_W(DIM_W), .MEM_W(MEM_W), .MIN_DIM(64)) dut (.*);

    always #4 clk = ~clk;

    typedef struct {
        longint due;
        string  tag;
        bit     v;
        longint bpp, fmt, w, h, str, ofs, sz;
        bit     chg;
    } exp_t;

    exp_t   sbq[$];
    longint cyc = 0;
    int     n_chk = 0, n_fail = 0;
    bit     done = 0;
    bit     m_held = 0;
    longint m_bpp, m_fmt, m_w, m_h, m_str, m_ofs, m_sz;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic drive(input bit en, input int depth, input int w, input int h,
                         input int vw, input int x, input int y,
                         input longint mem, input bit be, input string tag);
        exp_t e;
        longint bp, evw;
        bit ok;
        @(negedge clk);
        cfg_enable = {15'd0, en};
        cfg_depth  = 16'(depth);
        cfg_hres   = DIM_W'(w);
        cfg_vres   = DIM_W'(h);
        cfg_vwidth = DIM_W'(vw);
        cfg_xpan   = DIM_W'(x);
        cfg_ypan   = DIM_W'(y);
        mem_bytes  = MEM_W'(mem);
        big_endian = be;
        bp  = (depth == 16) ? 2 : (depth == 32) ? 4 : 0;
        evw = (vw < w) ? w : vw;
        e.due = cyc + 2;
        e.tag = tag;
        e.str = evw * bp;
        e.sz  = e.str * h;
        e.ofs = x * bp + longint'(y) * e.str;
        ok = en && bp != 0 && w >= 64 && h >= 64 && (e.ofs + e.sz <= mem);
        e.v   = ok;
        e.bpp = ok ? bp : 0;
        e.fmt = !ok ? 0 : (bp == 2) ? 1 : be ? 3 : 2;
        e.w   = ok ? w : 0;
        e.h   = ok ? h : 0;
        if (!ok) begin e.str = 0; e.sz = 0; e.ofs = 0; end
        e.chg = ok && (!m_held || e.bpp != m_bpp || e.fmt != m_fmt || e.w != m_w ||
                       e.h != m_h || e.str != m_str || e.ofs != m_ofs || e.sz != m_sz);
        if (e.chg) begin
            m_held = 1; m_bpp = e.bpp; m_fmt = e.fmt; m_w = e.w; m_h = e.h;
            m_str = e.str; m_ofs = e.ofs; m_sz = e.sz;
        end
        sbq.push_back(e);
    endtask

    // monitor: pops the item due this cycle
    always @(negedge clk) begin
        if (!rst && sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (geo_valid != e.v || longint'(bytes_pp) != e.bpp || longint'(pix_fmt) != e.fmt ||
                longint'(width) != e.w || longint'(height) != e.h || longint'(stride) != e.str ||
                longint'(start_ofs) != e.ofs || longint'(fb_size) != e.sz || mode_changed != e.chg) begin
                n_fail++;
                $display("FAIL %s: got v=%0b bpp=%0d fmt=%0d w=%0d h=%0d str=%0d ofs=%0d sz=%0d chg=%0b exp v=%0b bpp=%0d fmt=%0d w=%0d h=%0d str=%0d ofs=%0d sz=%0d chg=%0b",
                         e.tag, geo_valid, bytes_pp, pix_fmt, width, height, stride, start_ofs,
                         fb_size, mode_changed, e.v, e.bpp, e.fmt, e.w, e.h, e.str, e.ofs,
                         e.sz, e.chg);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got running expected finished");
        finish_run();
    end

    localparam longint MEM16M = 64'h100_0000;
    localparam longint MEMBIG = 64'hFFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        n_chk++;
        if (geo_valid || mode_changed || width != 0 || stride != 0 || start_ofs != 0 || fb_size != 0 || pix_fmt != 0) begin
            n_fail++;
            $display("FAIL R9 reset: got v=%0b chg=%0b w=%0d expected all zero", geo_valid, mode_changed, width);
        end
        @(negedge clk);
        rst = 1'b0;
        drive(0, 32, 640, 480, 0, 0, 0, MEM16M, 0, "R1 disabled");
        drive(1, 32, 640, 480, 0, 0, 0, MEM16M, 0, "R2 R4 R11 first mode");
        drive(1, 32, 640, 480, 0, 0, 0, MEM16M, 0, "R10 repeat");
        drive(1, 32, 640, 480, 0, 0, 0, MEM16M, 1, "R2 big-endian");
        drive(1, 16, 800, 600, 1024, 0, 0, MEM16M, 1, "R5 16bpp");
        drive(1, 16, 800, 600, 1024, 0, 0, MEM16M, 0, "R3 order ignored");
        drive(1, 24, 800, 600, 1024, 0, 0, MEM16M, 0, "R2 depth 24");
        drive(1, 16, 800, 600, 1024, 0, 0, MEM16M, 1, "R10 return after invalid");
        drive(1, 16, 63, 600, 1024, 0, 0, MEM16M, 0, "R7 width 63");
        drive(1, 16, 800, 63, 1024, 0, 0, MEM16M, 0, "R7 height 63");
        drive(1, 16, 64, 64, 0, 0, 0, MEM16M, 0, "R7 R9 exact 64");
        drive(1, 32, 640, 480, 4096, 3, 1000, MEMBIG, 0, "R6 pan");
        drive(1, 32, 640, 480, 100, 0, 0, MEM16M, 0, "R4 clamp");
        drive(1, 32, 1024, 1024, 1024, 0, 0, 64'h40_0000, 0, "R8 exact fit");
        drive(1, 32, 1024, 1024, 1024, 1, 0, 64'h40_0000, 0, "R8 one past");
        drive(1, 32, 64, 64, 65535, 0, 65535, MEMBIG, 0, "R6 no wrap");
        drive(1, 32, 1024, 1024, 1024, 0, 0, 64'h40_0000, 0, "R10 R11 same as latched");
        drive(0, 32, 1024, 1024, 1024, 0, 0, 64'h40_0000, 0, "R1 enable dropped");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule